// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a synchronous host and an asynchronous 2M x 8 DRAM that has extended data out. It accepts one word request at a time over a request/ready handshake. Each request carries a 21-bit word address, a write flag and write data. The block turns each request into a sequence of row strobe, column strobe, write enable and output enable pulses on the memory pins. The upper 11 address bits select the row and the lower 10 bits select the column, and both are sent over one multiplexed address bus.

After an access the row stays open. A later request to the same row needs only a short column strobe cycle (fast page mode). A request to a different row first closes the open row, waits out the precharge time and then opens the new one. The block also closes a row on its own before the row strobe has been low for longer than the allowed maximum, even when every request hits that row. Writes are always early writes: write enable and the data bus are set up before the column strobe falls, so the memory never drives its outputs while the controller drives data. Read data is captured a set number of clocks after the column strobe falls and is returned with a one-cycle valid pulse. Every timing minimum is a parameter counted in controller clocks.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the row strobe, column strobe, write enable and output enable (all active low) are high, the data bus drive enable is low, ready is high and read-valid is low.
- R2: The row address (request bits 20:10) is on dram_addr in the cycle the row strobe falls. The column address (request bits 9:0, zero-extended to 11 bits) is on dram_addr in the cycle the column strobe falls.
- R3: After the row strobe falls, dram_addr keeps the row address for T_RAH cycles before it changes to the column.
- R4: Between one row activation and the next, the row strobe stays high for at least T_RP cycles.
- R5: A request whose row matches the open row runs a column cycle without any row strobe transition. The column strobe is low only while the row strobe is low.
- R6: A request to a row other than the open one raises the row strobe, precharges, and activates the requested row.
- R7: The row strobe is never low for more than T_RAS_MAX consecutive cycles. The open row is closed in time even when every request hits it.
- R8: Each column strobe pulse is low for exactly T_CAS cycles, and it is high for at least T_CP cycles before every falling edge.
- R9: For a write, write enable is low and the data bus is driven with the write data from at least one cycle before the column strobe falls until it rises. Output enable stays high throughout, and the written byte can later be read back.
- R10: For a read, output enable is low and the data bus is not driven. The data on the memory bus T_CAPTURE cycles after the column strobe falls is returned on rd_data with a read-valid pulse exactly one cycle long. A never-written location reads as whatever the memory returns.
- R11: Ready is low from the cycle after a request is accepted until the strobe sequence ends. A request presented while ready is low is ignored.
- R12: The data bus drive enable is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | 21 | Word address: row in 20:10, column in 9:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds new read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data returned by the memory |

## Verification
The assertions check the pin timing rules on every cycle:
- precharge length, row strobe low time and row-address hold;
- column strobe pulse and gap widths;
- the column strobe only inside an open row;
- early-write setup and no bus contention;
- the single-cycle read-valid pulse.

Only the bench's scenarios can show the other behaviours. These are the correct address split, whether a request caused a row activation (page hit against page miss), the data returned by a write-then-read, the forced close during a long run of page hits, and that a request offered while the block is busy leaves memory untouched.

// File: rtl/edo_ctrl_pkg.sv
// Package: shared state encoding and small helpers for the EDO DRAM controller.
// Assumes: used only at elaboration time by the controller modules.
package edo_ctrl_pkg;

    // Sequencer states of the strobe generator.
    typedef enum logic [2:0] {
        SQ_IDLE,       // waiting for a request; row may be open or closed
        SQ_PRECHARGE,  // row strobe high, counting precharge
        SQ_ROW,        // row strobe low, row address held
        SQ_COLSET,     // column address, write enable and data set up
        SQ_STROBE,     // column strobe low
        SQ_RECOVER     // column strobe high, column precharge
    } sq_state_t;

    // Larger of two integers, for counter sizing.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_row_tracker.sv
// Module: edo_row_tracker
// Holds the open-row register and its valid flag, and reports whether a
// requested row hits the open one.
// Assumes: act_i and close_i are never high in the same cycle.
module edo_row_tracker #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] act_row_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] req_row_i,
    output logic             open_o,
    output logic             hit_o
);

    logic [ROW_W-1:0] open_row_q;
    logic             open_q;

    // Record which row is open; closing clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
        end else if (close_i) begin
            open_q <= 1'b0;
        end else if (act_i) begin
            open_q     <= 1'b1;
            open_row_q <= act_row_i;
        end
    end

    assign open_o = open_q;
    assign hit_o  = open_q && (open_row_q == req_row_i);

endmodule

// File: rtl/edo_ras_age.sv
// Module: edo_ras_age
// Counts the cycles the row strobe has been low. It flags when the open row
// must be closed so that one more column cycle still ends in the limit.
// Assumes: ras_n_i is the registered row strobe driven to the pin.
module edo_ras_age #(
    parameter int T_RAS_MAX = 12000,
    parameter int CLOSE_AT  = 11990
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n_i,
    output logic near_o
);

    localparam int AGE_W = $clog2(T_RAS_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_SAT  = AGE_W'(T_RAS_MAX);
    localparam logic [AGE_W-1:0] AGE_NEAR = AGE_W'(CLOSE_AT);

    logic [AGE_W-1:0] age_q;

    // Saturating count of row-strobe-low cycles, cleared while it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (ras_n_i) begin
            age_q <= '0;
        end else if (age_q != AGE_SAT) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign near_o = (age_q >= AGE_NEAR);

endmodule

// File: rtl/edo_strobe_seq.sv
// Module: edo_strobe_seq
// State machine that issues the row/column strobe sequences, drives the
// multiplexed address and the write data, and captures read data.
// Assumes: 1 <= T_CAPTURE <= T_CAS + T_CP - 1; ROW_W >= COL_W; all
// timing counts are at least 1.
module edo_strobe_seq
    import edo_ctrl_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 8,
    parameter int T_RP      = 5,
    parameter int T_RAH     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_CAPTURE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic              req_we_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              open_i,
    input  logic              hit_i,
    input  logic              near_i,
    input  logic [DATA_W-1:0] dq_in_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              act_o,
    output logic [ROW_W-1:0]  act_row_o,
    output logic              close_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o
);

    localparam int CNT_TOP = max2(max2(T_RP, T_RAH), T_CAS + T_CP);
    localparam int CNT_W   = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RAH_LAST = CNT_W'(T_RAH - 1);
    localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] CP_LAST  = CNT_W'(T_CP - 1);
    localparam logic [CNT_W-1:0] CAP_AT   = CNT_W'(T_CAPTURE);

    sq_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  col_age_q;
    logic              pend_q;
    logic [ROW_W-1:0]  lat_row_q;
    logic [COL_W-1:0]  lat_col_q;
    logic              lat_we_q;
    logic [DATA_W-1:0] lat_wdata_q;

    logic              ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q;
    logic [ROW_W-1:0]  addr_q;
    logic [DATA_W-1:0] dq_out_q, rd_data_q;
    logic              rd_valid_q, act_q, close_q;
    logic              in_column;

    assign in_column = (state_q == SQ_STROBE) || (state_q == SQ_RECOVER);

    // Main sequencer: state, counters, strobes, address mux and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            cnt_q       <= '0;
            col_age_q   <= '0;
            pend_q      <= 1'b0;
            lat_row_q   <= '0;
            lat_col_q   <= '0;
            lat_we_q    <= 1'b0;
            lat_wdata_q <= '0;
            ras_n_q     <= 1'b1;
            cas_n_q     <= 1'b1;
            we_n_q      <= 1'b1;
            oe_n_q      <= 1'b1;
            dq_oe_q     <= 1'b0;
            addr_q      <= '0;
            dq_out_q    <= '0;
            rd_data_q   <= '0;
            rd_valid_q  <= 1'b0;
            act_q       <= 1'b0;
            close_q     <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            act_q      <= 1'b0;
            close_q    <= 1'b0;

            if (in_column) begin
                col_age_q <= col_age_q + 1'b1;
            end
            if (in_column && !lat_we_q && (col_age_q == CAP_AT)) begin
                rd_data_q  <= dq_in_i;
                rd_valid_q <= 1'b1;
            end

            unique case (state_q)
                SQ_IDLE: begin
                    if (req_valid_i) begin
                        lat_row_q   <= req_row_i;
                        lat_col_q   <= req_col_i;
                        lat_we_q    <= req_we_i;
                        lat_wdata_q <= req_wdata_i;
                        if (open_i && hit_i && !near_i) begin
                            addr_q   <= ROW_W'(req_col_i);
                            we_n_q   <= ~req_we_i;
                            dq_oe_q  <= req_we_i;
                            dq_out_q <= req_wdata_i;
                            oe_n_q   <= req_we_i;
                            state_q  <= SQ_COLSET;
                        end else if (open_i) begin
                            ras_n_q <= 1'b1;
                            close_q <= 1'b1;
                            pend_q  <= 1'b1;
                            cnt_q   <= '0;
                            state_q <= SQ_PRECHARGE;
                        end else begin
                            ras_n_q <= 1'b0;
                            addr_q  <= req_row_i;
                            act_q   <= 1'b1;
                            cnt_q   <= '0;
                            state_q <= SQ_ROW;
                        end
                    end else if (open_i && near_i) begin
                        ras_n_q <= 1'b1;
                        close_q <= 1'b1;
                        pend_q  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= SQ_PRECHARGE;
                    end
                end
                SQ_PRECHARGE: begin
                    if (cnt_q == RP_LAST) begin
                        if (pend_q) begin
                            ras_n_q <= 1'b0;
                            addr_q  <= lat_row_q;
                            act_q   <= 1'b1;
                            pend_q  <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= SQ_ROW;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_ROW: begin
                    if (cnt_q == RAH_LAST) begin
                        addr_q   <= ROW_W'(lat_col_q);
                        we_n_q   <= ~lat_we_q;
                        dq_oe_q  <= lat_we_q;
                        dq_out_q <= lat_wdata_q;
                        oe_n_q   <= lat_we_q;
                        state_q  <= SQ_COLSET;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_COLSET: begin
                    cas_n_q   <= 1'b0;
                    cnt_q     <= '0;
                    col_age_q <= '0;
                    state_q   <= SQ_STROBE;
                end
                SQ_STROBE: begin
                    if (cnt_q == CAS_LAST) begin
                        cas_n_q <= 1'b1;
                        we_n_q  <= 1'b1;
                        dq_oe_q <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= SQ_RECOVER;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_RECOVER: begin
                    if (cnt_q == CP_LAST) begin
                        oe_n_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign req_ready_o = (state_q == SQ_IDLE);
    assign rd_data_o   = rd_data_q;
    assign rd_valid_o  = rd_valid_q;
    assign act_o       = act_q;
    assign act_row_o   = lat_row_q;
    assign close_o     = close_q;
    assign ras_n_o     = ras_n_q;
    assign cas_n_o     = cas_n_q;
    assign we_n_o      = we_n_q;
    assign oe_n_o      = oe_n_q;
    assign addr_o      = addr_q;
    assign dq_out_o    = dq_out_q;
    assign dq_oe_o     = dq_oe_q;

endmodule

// File: rtl/edo_dram_ctrl.sv
// Module: edo_dram_ctrl (top)
// Host-side request/ready front end for an EDO page-mode DRAM. It splits
// the word address into row and column, keeps rows open for page hits and
// forces a close before the maximum row-strobe-low time.
// Assumes: every timing count is in controller clocks and at least 1;
// T_RAS_MAX is well above T_RAH + 2*(1 + T_CAS + T_CP).
module edo_dram_ctrl #(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 8,
    parameter int T_RP      = 5,
    parameter int T_RAH     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_CAPTURE = 3,
    parameter int T_RAS_MAX = 12000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   req_we,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   rd_valid,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);

    localparam int ADDR_W   = ROW_W + COL_W;
    localparam int COL_LEN  = 1 + T_CAS + T_CP;
    localparam int CLOSE_AT = T_RAS_MAX - COL_LEN - 2;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             row_open, row_hit, age_near;
    logic             act_pulse, close_pulse;
    logic [ROW_W-1:0] act_row;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    edo_row_tracker #(
        .ROW_W (ROW_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act_pulse),
        .act_row_i (act_row),
        .close_i   (close_pulse),
        .req_row_i (req_row),
        .open_o    (row_open),
        .hit_o     (row_hit)
    );

    edo_ras_age #(
        .T_RAS_MAX (T_RAS_MAX),
        .CLOSE_AT  (CLOSE_AT)
    ) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_n_i (dram_ras_n),
        .near_o  (age_near)
    );

    edo_strobe_seq #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DATA_W    (DATA_W),
        .T_RP      (T_RP),
        .T_RAH     (T_RAH),
        .T_CAS     (T_CAS),
        .T_CP      (T_CP),
        .T_CAPTURE (T_CAPTURE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_row_i   (req_row),
        .req_col_i   (req_col),
        .req_we_i    (req_we),
        .req_wdata_i (req_wdata),
        .open_i      (row_open),
        .hit_i       (row_hit),
        .near_i      (age_near),
        .dq_in_i     (dram_dq_in),
        .rd_data_o   (rd_data),
        .rd_valid_o  (rd_valid),
        .act_o       (act_pulse),
        .act_row_o   (act_row),
        .close_o     (close_pulse),
        .ras_n_o     (dram_ras_n),
        .cas_n_o     (dram_cas_n),
        .we_n_o      (dram_we_n),
        .oe_n_o      (dram_oe_n),
        .addr_o      (dram_addr),
        .dq_out_o    (dram_dq_out),
        .dq_oe_o     (dram_dq_oe)
    );

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
// Module: edo_dram_ctrl_chk
// Pin-level timing checker for edo_dram_ctrl, attached by bind.
// Assumes: the same timing parameters as the controller instance.
module edo_dram_ctrl_chk #(
    parameter int ROW_W     = 11,
    parameter int T_RP      = 5,
    parameter int T_RAH     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RAS_MAX = 12000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic [ROW_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe
);

    localparam int HI_W  = $clog2(T_RP + 1);
    localparam int LO_W  = $clog2(T_RAS_MAX + 1);
    localparam int RH_W  = $clog2(T_RAH + 1);
    localparam int CL_W  = $clog2(T_CAS + 2);
    localparam int CH_W  = $clog2(T_CP + 1);
    localparam logic [HI_W-1:0] HI_SAT = HI_W'(T_RP);
    localparam logic [LO_W-1:0] LO_SAT = LO_W'(T_RAS_MAX);
    localparam logic [RH_W-1:0] RH_SAT = RH_W'(T_RAH);
    localparam logic [CL_W-1:0] CL_SAT = CL_W'(T_CAS + 1);
    localparam logic [CL_W-1:0] CL_EXP = CL_W'(T_CAS);
    localparam logic [CH_W-1:0] CH_SAT = CH_W'(T_CP);

    logic [HI_W-1:0] hi_cnt;
    logic [LO_W-1:0] lo_cnt;
    logic [RH_W-1:0] rah_cnt;
    logic [CL_W-1:0] cas_lo;
    logic [CH_W-1:0] cas_hi;

    // Run-length counters of strobe levels; reset counts as fully precharged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= HI_SAT;
            lo_cnt  <= '0;
            rah_cnt <= '0;
            cas_lo  <= '0;
            cas_hi  <= CH_SAT;
        end else begin
            hi_cnt  <= !dram_ras_n ? '0 : (hi_cnt == HI_SAT ? hi_cnt : hi_cnt + 1'b1);
            lo_cnt  <= dram_ras_n ? '0 : (lo_cnt == LO_SAT ? lo_cnt : lo_cnt + 1'b1);
            rah_cnt <= dram_ras_n ? '0 : (rah_cnt == RH_SAT ? rah_cnt : rah_cnt + 1'b1);
            cas_lo  <= dram_cas_n ? '0 : (cas_lo == CL_SAT ? cas_lo : cas_lo + 1'b1);
            cas_hi  <= !dram_cas_n ? '0 : (cas_hi == CH_SAT ? cas_hi : cas_hi + 1'b1);
        end
    end

    p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && rah_cnt != '0 && rah_cnt < RH_SAT) |-> $stable(dram_addr));

    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_cnt >= HI_SAT));

    p_cas_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    p_ras_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (lo_cnt < LO_SAT));

    p_cas_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> (cas_lo == CL_EXP));

    p_cas_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (cas_hi >= CH_SAT));

    p_early_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_cas_n && dram_we_n));

    p_no_contention_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .ROW_W     (ROW_W),
    .T_RP      (T_RP),
    .T_RAH     (T_RAH),
    .T_CAS     (T_CAS),
    .T_CP      (T_CP),
    .T_RAS_MAX (T_RAS_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .dram_dq_oe (dram_dq_oe)
);

// File: tb/edo_dram_ctrl_bench.sv
// Directed bench for edo_dram_ctrl with a behavioural EDO memory model.
module edo_dram_ctrl_bench;

    localparam int T_RP      = 5;
    localparam int T_RAH     = 2;
    localparam int T_CAS     = 2;
    localparam int T_CP      = 2;
    localparam int T_CAPTURE = 3;
    localparam int T_RAS_MAX = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [10:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [7:0]  dram_dq_out;
    logic [7:0]  dram_dq_in = 8'hEE;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    edo_dram_ctrl #(
        .T_RP (T_RP), .T_RAH (T_RAH), .T_CAS (T_CAS), .T_CP (T_CP),
        .T_CAPTURE (T_CAPTURE), .T_RAS_MAX (T_RAS_MAX)
    ) u_edo_dram_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_we (req_we), .req_wdata (req_wdata),
        .rd_data (rd_data), .rd_valid (rd_valid), .dram_addr (dram_addr),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
        .dram_oe_n (dram_oe_n), .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe),
        .dram_dq_in (dram_dq_in)
    );

    always #4 clk = ~clk;  // 125 MHz

    // ---------------- memory model and pin monitor ----------------
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    int act_cnt = 0, max_lo = 0, lo_len = 0, hi_len = 1000, rah_seen = 0;
    int cas_lo_len = 0, cas_hi_len = 1000;
    int v_rah = 0, v_rp = 0, v_casw = 0, v_cp = 0, v_wr = 0, v_cont = 0, v_cir = 0;
    logic [10:0] cur_row = '0;
    logic [9:0]  last_col = '0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && p_ras) begin
                act_cnt++;
                cur_row = dram_addr;
                if (hi_len < T_RP) v_rp++;
                lo_len = 1;
                rah_seen = 1;
            end else if (!dram_ras_n) begin
                lo_len++;
                if (rah_seen < T_RAH) begin
                    if (dram_addr != cur_row) v_rah++;
                    rah_seen++;
                end
            end else begin
                hi_len = p_ras ? hi_len + 1 : 1;
            end
            if (lo_len > max_lo) max_lo = lo_len;
            if (dram_ras_n) lo_len = 0;

            if (!dram_cas_n && p_cas) begin
                if (dram_ras_n) v_cir++;
                if (cas_hi_len < T_CP) v_cp++;
                last_col = dram_addr[9:0];
                cas_lo_len = 1;
                if (!dram_we_n) begin
                    if (!(p_we == 1'b0 && dram_dq_oe && dram_oe_n)) v_wr++;
                    mem[int'({cur_row, last_col})] = dram_dq_out;
                end else begin
                    dram_dq_in = mem.exists(int'({cur_row, last_col})) ?
                                 mem[int'({cur_row, last_col})] : 8'hA5;
                end
            end else if (!dram_cas_n) begin
                cas_lo_len++;
                if (!dram_we_n && !dram_dq_oe) v_wr++;
            end else begin
                if (!p_cas && cas_lo_len != T_CAS) v_casw++;
                cas_hi_len = p_cas ? cas_hi_len + 1 : 1;
            end
            if (dram_oe_n || (dram_ras_n && dram_cas_n)) dram_dq_in = 8'hEE;
            if (dram_dq_oe && !dram_oe_n) v_cont++;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_of(input logic [20:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hA5;
    endfunction

    task automatic issue(input bit we, input logic [20:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [20:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        shadow[int'(a)] = d;
        wait_ready();
    endtask

    task automatic do_read(input logic [20:0] a, output logic [7:0] d);
        int n = 0;
        issue(1'b0, a, 8'h00);
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        d = rd_data;
        check(rd_valid, "R10 read-valid seen", rd_valid, 1);
        @(negedge clk);
        check(!rd_valid, "R10 read-valid one cycle", rd_valid, 0);
        wait_ready();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        check(!dram_dq_oe && !rd_valid, "R1 bus off, no read-valid", {dram_dq_oe, rd_valid}, 0);
        check(req_ready, "R1 ready high", req_ready, 1);
    endtask

    task automatic t_random_cycle();
        logic [20:0] a = {11'h155, 10'h02A};
        logic [7:0] d;
        int a0 = act_cnt;
        do_write(a, 8'h3C);
        check(act_cnt == a0 + 1, "R6 closed row activates once", act_cnt - a0, 1);
        check(cur_row == a[20:10], "R2 row address at RAS fall", cur_row, a[20:10]);
        check(last_col == a[9:0], "R2 column address at CAS fall", last_col, a[9:0]);
        a0 = act_cnt;
        do_read(a, d);
        check(d == 8'h3C, "R9 R10 write then read", d, 8'h3C);
        check(act_cnt == a0, "R5 read hits open row", act_cnt - a0, 0);
    endtask

    task automatic t_page_burst();
        logic [7:0] d;
        int a0 = act_cnt;
        for (int i = 0; i < 4; i++) do_write({11'h155, 10'(100 + i)}, 8'(8'h50 + i));
        for (int i = 0; i < 4; i++) begin
            do_read({11'h155, 10'(100 + i)}, d);
            check(d == 8'(8'h50 + i), "R5 page-mode data", d, 8'(8'h50 + i));
        end
        check(act_cnt == a0 || act_cnt == a0 + 1, "R5 no per-access activation", act_cnt - a0, 0);
        do_read({11'h155, 10'h3FF}, d);
        check(d == 8'hA5, "R10 unwritten location", d, 8'hA5);
    endtask

    task automatic t_page_miss();
        logic [7:0] d;
        logic [20:0] b = {11'h7FF, 10'h001};
        int a0 = act_cnt;
        do_write(b, 8'hC3);
        check(act_cnt == a0 + 1, "R6 miss reactivates", act_cnt - a0, 1);
        check(cur_row == 11'h7FF, "R2 R6 new row", cur_row, 11'h7FF);
        do_read({11'h155, 10'h02A}, d);
        check(d == 8'h3C, "R6 old row after miss", d, 8'h3C);
        do_read(b, d);
        check(d == 8'hC3, "R6 new row data", d, 8'hC3);
        check(v_rp == 0, "R4 precharge width", v_rp, 0);
    endtask

    task automatic t_ras_limit();
        logic [7:0] d;
        int a0 = act_cnt;
        for (int i = 0; i < 20; i++) begin
            do_read({11'h0F0, 10'(i)}, d);
            check(d == expect_of({11'h0F0, 10'(i)}), "R7 data during long hit run", d, 8'hA5);
        end
        check(act_cnt - a0 >= 2, "R7 forced close under page hits", act_cnt - a0, 2);
        check(max_lo <= T_RAS_MAX, "R7 RAS low bound", max_lo, T_RAS_MAX);
    endtask

    task automatic t_busy_ignored();
        logic [7:0] d;
        logic [20:0] y = {11'h0F0, 10'h200};
        issue(1'b1, {11'h0F0, 10'h201}, 8'h11);
        shadow[int'({11'h0F0, 10'h201})] = 8'h11;
        check(!req_ready, "R11 ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_we = 1'b1; req_addr = y; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        wait_ready();
        do_read(y, d);
        check(d == expect_of(y), "R11 busy request ignored", d, expect_of(y));
    endtask

    task automatic t_pin_rules();
        check(v_rah == 0, "R3 row address hold", v_rah, 0);
        check(v_casw == 0, "R8 CAS low width", v_casw, 0);
        check(v_cp == 0, "R8 CAS precharge", v_cp, 0);
        check(v_cir == 0, "R5 CAS only inside open row", v_cir, 0);
        check(v_wr == 0, "R9 early write setup and hold", v_wr, 0);
        check(v_cont == 0, "R12 no bus contention", v_cont, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_random_cycle();
        t_page_burst();
        t_page_miss();
        t_ras_limit();
        t_busy_ignored();
        t_pin_rules();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule